// File: doc/BRIEF.md
# Serial Port Control Register with Interrupt Gating

This block holds the eight-bit control word of a serial port that runs either asynchronously or synchronously, and it contains the logic that depends directly on that word. Software writes and reads the word over a single-cycle bus. Receive status comes in as event inputs: a frame has arrived, its multiprocessor bit, a framing error, and an overrun. The block keeps three sticky receive flags. The four interrupt requests are derived from those flags and from the transmitter's level inputs, each under its own enable.

A wake-up filter is used on multi-drop links. While its enable is set, arriving frames leave every receive flag untouched and cause no receive interrupt. The exception is a frame that carries a multiprocessor bit of 1. That frame is taken in as normal, and the hardware then drops the filter enable. The two clock-enable bits are decoded together with the mode input. The decode gives the clock source and the role of the serial clock pin. Combinations with no defined meaning are reported on an error output.

Top module: `serctl_top`

## Requirements
- R1: After reset the control word reads 0x00, and all flags, all interrupt requests and `clkCfgErr` are 0. `sckMode` is 0 (general port).
- R2: A bus write stores `busWdata` in the control word, and `busRdata` returns it from the next cycle on. Bit layout from bit 7 down to bit 0: transmit-empty IRQ enable, receive IRQ enable, transmit enable, receive enable, wake-up filter enable, transmit-end IRQ enable, clock-enable 1, clock-enable 0.
- R3: `irqTxEmpty` is 1 only when `txEmpty` and bit 7 are both 1. `irqTxEnd` is 1 only when `txEnd` and bit 2 are both 1.
- R4: Bit 6 gates both receive interrupts. `irqRxFull` follows `rxFull`, and `irqRxErr` follows the OR of `frameErrFlag` and `overrunFlag`.
- R5: `rxPinEn` follows bit 4 and `txPinEn` follows bit 5. While bit 4 is 0, a frame event changes no flag.
- R6: While bit 3 is 1, a frame with `mpBit`=0 sets no flag and so raises no receive interrupt.
- R7: A frame with `mpBit`=1 received while bits 4 and 3 are 1 is accepted, and bit 3 reads 0 afterwards. If a bus write happens in the same cycle, this hardware clear wins over the written bit 3.
- R8: An accepted frame sets `rxFull`. It also sets `frameErrFlag` when `frameErr` is 1 and `overrunFlag` when `overrunErr` is 1. Each flag stays set until its clear strobe, one cycle later. A set in the same cycle as the clear wins.
- R9: The clock is decoded from bits [1:0] (cke) and `syncMode`. cke=00 gives an internal clock, with `sckMode` 00 (port) in asynchronous mode and 01 (clock output) in synchronous mode. cke=01 in asynchronous mode gives an internal clock with `sckMode` 01. cke=10 gives an external clock (`clkExternal`=1) with `sckMode` 10 (clock input) in either mode.
- R10: cke=11, or cke=01 with `syncMode`=1, sets `clkCfgErr`. In that case `sckMode` is 00 and `clkExternal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Bus write strobe |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Control word readback |
| syncMode | input | 1 | 1 = synchronous, 0 = asynchronous |
| frameRx | input | 1 | One-cycle pulse: a frame was received |
| mpBit | input | 1 | Multiprocessor bit of that frame |
| frameErr | input | 1 | The frame had a framing error |
| overrunErr | input | 1 | The frame overran the receive buffer |
| txEmpty | input | 1 | Transmit data buffer is empty (level) |
| txEnd | input | 1 | Transmission has ended (level) |
| clrRxFull | input | 1 | Clear strobe for `rxFull` |
| clrFrameErr | input | 1 | Clear strobe for `frameErrFlag` |
| clrOverrun | input | 1 | Clear strobe for `overrunFlag` |
| rxFull | output | 1 | Sticky receive-full flag |
| frameErrFlag | output | 1 | Sticky framing-error flag |
| overrunFlag | output | 1 | Sticky overrun flag |
| irqTxEmpty | output | 1 | Transmit-data-empty request |
| irqTxEnd | output | 1 | Transmit-end request |
| irqRxFull | output | 1 | Receive-full request |
| irqRxErr | output | 1 | Receive-error request |
| rxPinEn | output | 1 | Receive pin used as data pin |
| txPinEn | output | 1 | Transmit pin used as data pin |
| clkExternal | output | 1 | Clock is taken from the pin |
| sckMode | output | 2 | Serial clock pin: 00 port, 01 output, 10 input |
| clkCfgErr | output | 1 | Reserved clock combination selected |

## Verification
Some relations are checked by assertions on every cycle:
- Each interrupt request is never active while its enable bit reads 0.
- A reserved clock selection always forces the pin to port function.
- A filtered frame never raises `rxFull`.
- An accepted address frame always clears the filter enable one cycle later.
- A frame set beats a simultaneous clear.

Other behaviour can only be shown by the bench's scenarios: the exact readback of written words, the full clock decode table for both modes, each flag's individual clear, and the ordering between a bus write and the hardware clear in one cycle.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int CTL_W  = 8;
  localparam int CKE_W  = 2;
  localparam int NFLAG  = 3;

  typedef struct packed {
    logic txIe;
    logic rxIe;
    logic txEn;
    logic rxEn;
    logic mpIe;
    logic tendIe;
    logic [CKE_W-1:0] cke;
  } ctlReg_t;

  typedef struct packed {
    logic accept;
    logic ferIn;
    logic oerIn;
  } rxStrobe_t;

  typedef enum logic [1:0] {
    SCK_PORT = 2'b00,
    SCK_OUT  = 2'b01,
    SCK_IN   = 2'b10
  } sckFn_t;
endpackage

// File: rtl/serctl_ctrl.sv
module serctl_ctrl
  import serctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busWe,
  input  logic [CTL_W-1:0] busWdata,
  input  logic             frameRx,
  input  logic             mpBit,
  input  logic             frameErr,
  input  logic             overrunErr,
  output ctlReg_t          cfg,
  output rxStrobe_t        strobe
);
  ctlReg_t cfgQ;
  ctlReg_t cfgNext;
  logic    frameSeen;
  logic    mpWake;

  assign frameSeen = frameRx & cfgQ.rxEn;
  assign mpWake    = frameSeen & cfgQ.mpIe & mpBit;

  always_comb begin
    cfgNext = cfgQ;
    if (busWe) cfgNext = ctlReg_t'(busWdata);
    if (mpWake) cfgNext.mpIe = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgQ <= '0;
    else        cfgQ <= cfgNext;
  end

  assign strobe.accept = frameSeen & (~cfgQ.mpIe | mpBit);
  assign strobe.ferIn  = frameErr;
  assign strobe.oerIn  = overrunErr;
  assign cfg = cfgQ;
endmodule

// File: rtl/serctl_dp.sv
module serctl_dp
  import serctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctlReg_t   cfg,
  input  rxStrobe_t strobe,
  input  logic      syncMode,
  input  logic      txEmpty,
  input  logic      txEnd,
  input  logic [NFLAG-1:0] clrVec,
  output logic [NFLAG-1:0] flagVec,
  output logic      irqTxEmpty,
  output logic      irqTxEnd,
  output logic      irqRxFull,
  output logic      irqRxErr,
  output logic      clkExternal,
  output sckFn_t    sckMode,
  output logic      clkCfgErr
);
  logic [NFLAG-1:0] setVec;

  assign setVec[0] = strobe.accept;
  assign setVec[1] = strobe.accept & strobe.ferIn;
  assign setVec[2] = strobe.accept & strobe.oerIn;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flagVec[i] <= 1'b0;
      else if (setVec[i]) flagVec[i] <= 1'b1;
      else if (clrVec[i]) flagVec[i] <= 1'b0;
    end
  end

  assign irqTxEmpty = cfg.txIe & txEmpty;
  assign irqTxEnd   = cfg.tendIe & txEnd;
  assign irqRxFull  = cfg.rxIe & flagVec[0];
  assign irqRxErr   = cfg.rxIe & (flagVec[1] | flagVec[2]);

  always_comb begin
    clkExternal = 1'b0;
    clkCfgErr   = 1'b0;
    sckMode     = SCK_PORT;
    unique case (cfg.cke)
      2'b00: sckMode = syncMode ? SCK_OUT : SCK_PORT;
      2'b01: begin
        if (syncMode) clkCfgErr = 1'b1;
        else          sckMode   = SCK_OUT;
      end
      2'b10: begin
        clkExternal = 1'b1;
        sckMode     = SCK_IN;
      end
      default: clkCfgErr = 1'b1;
    endcase
  end
endmodule

// File: rtl/serctl_top.sv
module serctl_top
  import serctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busWe,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       syncMode,
  input  logic       frameRx,
  input  logic       mpBit,
  input  logic       frameErr,
  input  logic       overrunErr,
  input  logic       txEmpty,
  input  logic       txEnd,
  input  logic       clrRxFull,
  input  logic       clrFrameErr,
  input  logic       clrOverrun,
  output logic       rxFull,
  output logic       frameErrFlag,
  output logic       overrunFlag,
  output logic       irqTxEmpty,
  output logic       irqTxEnd,
  output logic       irqRxFull,
  output logic       irqRxErr,
  output logic       rxPinEn,
  output logic       txPinEn,
  output logic       clkExternal,
  output logic [1:0] sckMode,
  output logic       clkCfgErr
);
  ctlReg_t          cfg;
  rxStrobe_t        strobe;
  logic [NFLAG-1:0] flagVec;
  sckFn_t           sckFn;

  serctl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busWdata(busWdata),
    .frameRx(frameRx), .mpBit(mpBit), .frameErr(frameErr),
    .overrunErr(overrunErr), .cfg(cfg), .strobe(strobe)
  );

  serctl_dp u_dp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .strobe(strobe),
    .syncMode(syncMode), .txEmpty(txEmpty), .txEnd(txEnd),
    .clrVec({clrOverrun, clrFrameErr, clrRxFull}), .flagVec(flagVec),
    .irqTxEmpty(irqTxEmpty), .irqTxEnd(irqTxEnd), .irqRxFull(irqRxFull),
    .irqRxErr(irqRxErr), .clkExternal(clkExternal), .sckMode(sckFn),
    .clkCfgErr(clkCfgErr)
  );

  assign busRdata     = cfg;
  assign rxFull       = flagVec[0];
  assign frameErrFlag = flagVec[1];
  assign overrunFlag  = flagVec[2];
  assign rxPinEn      = cfg.rxEn;
  assign txPinEn      = cfg.txEn;
  assign sckMode      = sckFn;
endmodule

// File: rtl/serctl_chk.sv
module serctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] busRdata,
  input logic       frameRx,
  input logic       mpBit,
  input logic       clrRxFull,
  input logic       rxFull,
  input logic       irqTxEmpty,
  input logic       irqTxEnd,
  input logic       irqRxFull,
  input logic       irqRxErr,
  input logic [1:0] sckMode,
  input logic       clkCfgErr
);
  // R3
  a_r3_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!busRdata[7] |-> !irqTxEmpty) and (!busRdata[2] |-> !irqTxEnd));
  // R4
  a_r4_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !busRdata[6] |-> (!irqRxFull && !irqRxErr));
  // R6
  a_r6_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdata[3] && frameRx && !mpBit && !rxFull) |=> !rxFull);
  // R7
  a_r7_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdata[4] && busRdata[3] && frameRx && mpBit) |=> !busRdata[3]);
  // R8
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdata[4] && !busRdata[3] && frameRx && clrRxFull) |=> rxFull);
  // R10
  a_r10_reserved_port: assert property (@(posedge clk) disable iff (!rst_n)
    clkCfgErr |-> (sckMode == 2'b00));
endmodule

bind serctl_top serctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busRdata(busRdata), .frameRx(frameRx),
  .mpBit(mpBit), .clrRxFull(clrRxFull), .rxFull(rxFull),
  .irqTxEmpty(irqTxEmpty), .irqTxEnd(irqTxEnd), .irqRxFull(irqRxFull),
  .irqRxErr(irqRxErr), .sckMode(sckMode), .clkCfgErr(clkCfgErr)
);

// File: tb/test_serctl_top.sv
module test_serctl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busWe = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic syncMode = 0, frameRx = 0, mpBit = 0, frameErr = 0, overrunErr = 0;
  logic txEmpty = 0, txEnd = 0, clrRxFull = 0, clrFrameErr = 0, clrOverrun = 0;
  logic rxFull, frameErrFlag, overrunFlag, irqTxEmpty, irqTxEnd, irqRxFull, irqRxErr;
  logic rxPinEn, txPinEn, clkExternal, clkCfgErr;
  logic [1:0] sckMode;
  int nChk = 0, nErr = 0;

  always #4 clk = ~clk;

  serctl_top i_serctl_top (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk); busWe = 1; busWdata = v;
    @(negedge clk); busWe = 0;
  endtask

  task automatic frame(input logic mp, input logic fe, input logic oe);
    @(negedge clk); frameRx = 1; mpBit = mp; frameErr = fe; overrunErr = oe;
    @(negedge clk); frameRx = 0; mpBit = 0; frameErr = 0; overrunErr = 0;
  endtask

  task automatic clearAll();
    @(negedge clk); clrRxFull = 1; clrFrameErr = 1; clrOverrun = 1;
    @(negedge clk); clrRxFull = 0; clrFrameErr = 0; clrOverrun = 0;
  endtask

  task automatic tReset();
    #1;
    check("R1 ctl", busRdata, 8'h00);
    check("R1 flags", {rxFull, frameErrFlag, overrunFlag}, 0);
    check("R1 irqs", {irqTxEmpty, irqTxEnd, irqRxFull, irqRxErr}, 0);
    check("R1 sck", {sckMode, clkCfgErr}, 0);
  endtask

  task automatic tRegRw();
    wrReg(8'hA5); #1; check("R2 readA5", busRdata, 8'hA5);
    wrReg(8'h5A); #1; check("R2 read5A", busRdata, 8'h5A);
    wrReg(8'h00);
  endtask

  task automatic tTxIrq();
    @(negedge clk); txEmpty = 1; txEnd = 1; #1;
    check("R3 off", {irqTxEmpty, irqTxEnd}, 2'b00);
    wrReg(8'h80); #1; check("R3 empty", {irqTxEmpty, irqTxEnd}, 2'b10);
    wrReg(8'h04); #1; check("R3 end", {irqTxEmpty, irqTxEnd}, 2'b01);
    @(negedge clk); txEmpty = 0; txEnd = 0;
    wrReg(8'h00);
  endtask

  task automatic tRxOff();
    frame(0, 1, 1); #1;
    check("R5 ignored", {rxFull, frameErrFlag, overrunFlag}, 0);
    check("R5 pins off", {rxPinEn, txPinEn}, 2'b00);
    wrReg(8'h30); #1; check("R5 pins on", {rxPinEn, txPinEn}, 2'b11);
  endtask

  task automatic tRxIrq();
    wrReg(8'h10);
    frame(0, 1, 0); #1;
    check("R8 set", {rxFull, frameErrFlag, overrunFlag}, 3'b110);
    check("R4 gated", {irqRxFull, irqRxErr}, 2'b00);
    wrReg(8'h50); #1; check("R4 on", {irqRxFull, irqRxErr}, 2'b11);
    @(negedge clk); clrRxFull = 1; @(negedge clk); clrRxFull = 0; #1;
    check("R8 clr full", {rxFull, frameErrFlag}, 2'b01);
    check("R4 err only", {irqRxFull, irqRxErr}, 2'b01);
    @(negedge clk); clrFrameErr = 1; @(negedge clk); clrFrameErr = 0; #1;
    check("R8 clr fer", irqRxErr, 1'b0);
    @(negedge clk); frameRx = 1; overrunErr = 1; clrRxFull = 1; clrOverrun = 1;
    @(negedge clk); frameRx = 0; overrunErr = 0; clrRxFull = 0; clrOverrun = 0; #1;
    check("R8 set wins", {rxFull, overrunFlag}, 2'b11);
    check("R4 ovr irq", irqRxErr, 1'b1);
    clearAll();
  endtask

  task automatic tMpFilter();
    wrReg(8'h58);
    frame(0, 1, 1); #1;
    check("R6 no flags", {rxFull, frameErrFlag, overrunFlag}, 0);
    check("R6 no irq", {irqRxFull, irqRxErr}, 0);
    check("R6 still on", busRdata, 8'h58);
    frame(1, 0, 0); #1;
    check("R7 accepted", rxFull, 1'b1);
    check("R7 bit cleared", busRdata, 8'h50);
    clearAll();
    wrReg(8'h58);
    @(negedge clk); busWe = 1; busWdata = 8'h78; frameRx = 1; mpBit = 1;
    @(negedge clk); busWe = 0; frameRx = 0; mpBit = 0; #1;
    check("R7 hw wins", busRdata, 8'h70);
    clearAll();
    frame(0, 0, 0); #1;
    check("R7 normal rx", rxFull, 1'b1);
    clearAll();
    wrReg(8'h00);
  endtask

  task automatic tClock();
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] eS; logic eX, eE;
        eS = 2'b00; eX = 0; eE = 0;
        if (c == 0) eS = (m == 1) ? 2'b01 : 2'b00;
        else if (c == 1 && m == 0) eS = 2'b01;
        else if (c == 2) begin eS = 2'b10; eX = 1; end
        else eE = 1;
        @(negedge clk); syncMode = m[0];
        wrReg(c[7:0]); #1;
        if (eE) check("R10 reserved", {sckMode, clkExternal, clkCfgErr}, {eS, eX, eE});
        else    check("R9 decode", {sckMode, clkExternal, clkCfgErr}, {eS, eX, eE});
      end
    end
    wrReg(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tReset();
    tRegRw();
    tTxIrq();
    tRxOff();
    tRxIrq();
    tMpFilter();
    tClock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule